// File: doc/BRIEF.md
# Manchester Character Transmitter with Frame Delimiters

This block serialises characters onto a single line output using Manchester coding. Every character is preceded by a start-of-frame marker. The marker is either a single coded start bit or a sync pattern three bit times long. The sync pattern is one of two shapes, and the shape tells the far end whether the character is a command or data. All line timing comes from `half_en`, an enable that pulses once per half-bit period. The line level can change only on a cycle in which `half_en` is high.

Characters arrive on a valid/ready stream. A character is taken on a clock edge where `s_valid` and `s_ready` are both high. From the cycle after that edge, `s_ready` stays low until the whole frame has been driven and the line has returned to idle. While `s_ready` is low, the upstream must hold its character or withdraw it, and anything on the data inputs is ignored. The command/data choice for a sync marker comes from one of two places. With variable-sync mode off, it comes from a static configuration bit. With variable-sync mode on, it comes from a sideband bit carried with each character. A DMA-fed stream can therefore switch the marker type on every character.

Top module: `manch_sfd_tx`

## Requirements
- R1: After reset `txd` is 1 and `s_ready` is 1. While no frame is in progress, `half_en` pulses leave `txd` at 1.
- R2: A character is accepted only on a clock edge where `s_valid` and `s_ready` are both 1. From the next cycle, `s_ready` is 0 for the rest of the frame. Data and valid changes during that time do not alter the frame being sent.
- R3: Each half-bit level appears on `txd` at the first `half_en` cycle after acceptance or after the previous level. It then holds until the next `half_en` cycle, however many clocks lie between the two.
- R4: Command sync marker (`cfg_sync_en`=1, command selected): six half-bit levels 1,1,1,0,0,0. The line is high for 1.5 bit times, then low for 1.5 bit times, with the transition in the middle of the second bit time.
- R5: Data sync marker (`cfg_sync_en`=1, data selected): six half-bit levels 0,0,0,1,1,1.
- R6: With `cfg_sync_en`=0, the marker is a single start bit sent as two half-bit levels: 0, then 1.
- R7: After the marker, the data bits go out LSB first. Each bit takes two half-bit levels: a 1 is sent as 1,0 and a 0 is sent as 0,1.
- R8: With `cfg_var_sync`=0, `cfg_cmd_sync`=1 selects the command marker and `cfg_cmd_sync`=0 selects the data marker. `s_sync` has no effect.
- R9: With `cfg_var_sync`=1, `s_sync`=1 selects the command marker and `s_sync`=0 selects the data marker. `cfg_cmd_sync` has no effect.
- R10: The configuration inputs and `s_sync` are sampled only at acceptance. Changing them during a frame does not alter that frame.
- R11: At the first `half_en` cycle after the last data half-bit, `txd` returns to 1. `s_ready` is 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| half_en | input | 1 | One-cycle pulse per half-bit period |
| cfg_sync_en | input | 1 | 1: three-bit sync marker; 0: single start bit |
| cfg_cmd_sync | input | 1 | Static marker choice: 1 command, 0 data |
| cfg_var_sync | input | 1 | 1: take marker choice from `s_sync` |
| s_valid | input | 1 | Character valid |
| s_ready | output | 1 | Block can accept a character |
| s_data | input | DATA_W | Character bits, bit 0 sent first |
| s_sync | input | 1 | Per-character marker choice: 1 command, 0 data |
| txd | output | 1 | Manchester line output, idles high |

## Verification
Two situations can coincide in one cycle. The first is the acceptance of a character together with a change of configuration in the very next cycle. The bench randomises `cfg_*` and `s_sync` right after each handshake, then compares every half-bit against a model built from the values held at acceptance. The second is a frame in progress while a new `s_valid` with fresh data is raised. The bench asserts a stray valid partway through some frames and checks that `s_ready` stays low and that the line still carries the original character. Random idle gaps between `half_en` pulses check that levels are held between ticks.

// File: rtl/mtx_pkg.sv
package mtx_pkg;

  typedef enum logic [1:0] {
    SFD_START = 2'd0,
    SFD_CMD   = 2'd1,
    SFD_DATA  = 2'd2
  } sfd_kind_e;

  localparam int SYNC_HALVES  = 6;
  localparam int START_HALVES = 2;

  // levels listed with the first-sent half in bit 0
  localparam logic [SYNC_HALVES-1:0]  CMD_SHAPE   = 6'b000111;
  localparam logic [SYNC_HALVES-1:0]  DATA_SHAPE  = 6'b111000;
  localparam logic [START_HALVES-1:0] START_SHAPE = 2'b10;

endpackage

// File: rtl/mtx_sfd_select.sv
module mtx_sfd_select
  import mtx_pkg::*;
(
  input  logic      cfg_sync_en,
  input  logic      cfg_cmd_sync,
  input  logic      cfg_var_sync,
  input  logic      s_sync,
  output sfd_kind_e kind
);

  logic want_cmd;

  // per-character sideband overrides the static bit in variable mode
  assign want_cmd = cfg_var_sync ? s_sync : cfg_cmd_sync;

  always_comb begin
    if (!cfg_sync_en)   kind = SFD_START;
    else if (want_cmd)  kind = SFD_CMD;
    else                kind = SFD_DATA;
  end

endmodule

// File: rtl/mtx_frame_build.sv
module mtx_frame_build
  import mtx_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int FRAME_W = SYNC_HALVES + 2 * DATA_W,
  localparam int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  sfd_kind_e           kind,
  input  logic [DATA_W-1:0]   data,
  output logic [FRAME_W-1:0]  frame,
  output logic [CNT_W-1:0]    len
);

  localparam int BODY_W = 2 * DATA_W;
  localparam int PAD_W  = SYNC_HALVES - START_HALVES;

  logic [BODY_W-1:0] body;

  // each bit becomes two half-bit levels: true level then its complement
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign body[2*i]   = data[i];
    assign body[2*i+1] = ~data[i];
  end

  always_comb begin
    unique case (kind)
      SFD_CMD: begin
        frame = {body, CMD_SHAPE};
        len   = CNT_W'(FRAME_W);
      end
      SFD_DATA: begin
        frame = {body, DATA_SHAPE};
        len   = CNT_W'(FRAME_W);
      end
      default: begin
        frame = {{PAD_W{1'b1}}, body, START_SHAPE};
        len   = CNT_W'(START_HALVES + BODY_W);
      end
    endcase
  end

endmodule

// File: rtl/mtx_serializer.sv
module mtx_serializer #(
  parameter int FRAME_W = 22,
  localparam int CNT_W  = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               half_en,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  input  logic [CNT_W-1:0]   len,
  output logic               busy,
  output logic               txd
);

  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '1;
      remain <= '0;
      busy   <= 1'b0;
      txd    <= 1'b1;
    end else if (load) begin
      shreg  <= frame;
      remain <= len;
      busy   <= 1'b1;
    end else if (busy && half_en) begin
      if (remain != '0) begin
        txd    <= shreg[0];
        shreg  <= {1'b1, shreg[FRAME_W-1:1]};
        remain <= remain - 1'b1;
      end else begin
        txd  <= 1'b1;
        busy <= 1'b0;
      end
    end
  end

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd); // R1
  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    !half_en |=> $stable(txd)); // R3
  AST_LOAD_TAKES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy); // R2
  AST_END_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && half_en && remain == '0) |=> (!busy && txd)); // R11
  AST_REMAIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    remain <= CNT_W'(FRAME_W)); // R3

endmodule

// File: rtl/manch_sfd_tx.sv
module manch_sfd_tx
  import mtx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              half_en,
  input  logic              cfg_sync_en,
  input  logic              cfg_cmd_sync,
  input  logic              cfg_var_sync,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_sync,
  output logic              txd
);

  localparam int FRAME_W = SYNC_HALVES + 2 * DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  sfd_kind_e          kind;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   len;
  logic               busy;
  logic               take;

  assign s_ready = !busy;
  assign take    = s_valid && s_ready;

  mtx_sfd_select u_sel (
    .cfg_sync_en  (cfg_sync_en),
    .cfg_cmd_sync (cfg_cmd_sync),
    .cfg_var_sync (cfg_var_sync),
    .s_sync       (s_sync),
    .kind         (kind)
  );

  mtx_frame_build #(.DATA_W(DATA_W)) u_build (
    .kind  (kind),
    .data  (s_data),
    .frame (frame),
    .len   (len)
  );

  mtx_serializer #(.FRAME_W(FRAME_W)) u_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .half_en (half_en),
    .load    (take),
    .frame   (frame),
    .len     (len),
    .busy    (busy),
    .txd     (txd)
  );

  AST_NO_SECOND_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !s_ready); // R2
  AST_TAKE_KEEPS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> txd); // R3

endmodule

// File: tb/manch_sfd_tx_tb_top.sv
module manch_sfd_tx_tb_top;

  localparam int DW = 8;
  localparam int FW = 6 + 2 * DW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic half_en = 1'b0;
  logic cfg_sync_en = 1'b1, cfg_cmd_sync = 1'b1, cfg_var_sync = 1'b0;
  logic s_valid = 1'b0, s_sync = 1'b0;
  logic [DW-1:0] s_data = '0;
  logic s_ready, txd;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  manch_sfd_tx #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .half_en(half_en),
    .cfg_sync_en(cfg_sync_en), .cfg_cmd_sync(cfg_cmd_sync),
    .cfg_var_sync(cfg_var_sync), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_sync(s_sync), .txd(txd)
  );

  task automatic chk(input int act, input int exp, input string req, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // expected half-bit levels, first-sent at index 0
  function automatic void model(input logic [DW-1:0] d, input bit sen, input bit cmd,
                                input bit vm, input bit ss,
                                output logic [FW-1:0] e, output int n, output int sfd_n,
                                output bit is_cmd);
    int k = 0;
    e = '1;
    is_cmd = vm ? ss : cmd;
    if (!sen) begin
      e[0] = 1'b0; e[1] = 1'b1; k = 2;
    end else begin
      for (int j = 0; j < 6; j++) e[j] = is_cmd ? (j < 3) : (j >= 3);
      k = 6;
    end
    sfd_n = k;
    for (int i = 0; i < DW; i++) begin
      e[k] = d[i]; e[k+1] = !d[i]; k += 2;
    end
    n = k;
  endfunction

  task automatic pulse();
    @(negedge clk) half_en = 1'b1;
    @(negedge clk) half_en = 1'b0;
  endtask

  task automatic send(input logic [DW-1:0] d, input bit sen, input bit cmd, input bit vm,
                      input bit ss, input bit scramble, input int gap_max, input bit junk);
    logic [FW-1:0] e;
    int n, sfd_n;
    bit is_cmd;
    string tag, mtag;
    @(negedge clk);
    while (!s_ready) @(negedge clk);
    cfg_sync_en = sen; cfg_cmd_sync = cmd; cfg_var_sync = vm;
    s_sync = ss; s_data = d; s_valid = 1'b1;
    model(d, sen, cmd, vm, ss, e, n, sfd_n, is_cmd);
    mtag = scramble ? "/R10" : "";
    chk(s_ready, 1, "R2", "ready at handshake");
    @(negedge clk);
    s_valid = 1'b0;
    chk(s_ready, 0, "R2", "ready after handshake");
    chk(txd, 1, "R3", "no level before first tick");
    if (scramble) begin
      cfg_sync_en = 1'($urandom); cfg_cmd_sync = 1'($urandom);
      cfg_var_sync = 1'($urandom); s_sync = 1'($urandom); s_data = DW'($urandom);
    end
    for (int k = 0; k < n; k++) begin
      if (junk && k == 3) begin
        s_valid = 1'b1; s_data = DW'($urandom);
      end
      if (k < sfd_n)
        tag = !sen ? "R6" : $sformatf("%s/%s", is_cmd ? "R4" : "R5", vm ? "R9" : "R8");
      else
        tag = "R7";
      tag = {tag, mtag};
      pulse();
      chk(txd, e[k], tag, $sformatf("half %0d", k));
      chk(s_ready, 0, "R2", "ready low mid-frame");
      repeat ($urandom_range(0, gap_max)) begin
        @(negedge clk);
        chk(txd, e[k], "R3", $sformatf("hold half %0d", k));
      end
    end
    s_valid = 1'b0;
    pulse();
    chk(txd, 1, "R11", "line idle after frame");
    chk(s_ready, 1, "R11", "ready after release");
  endtask

  initial begin
    void'($urandom(32'h5EED_2024));
    repeat (3) @(negedge clk);
    chk(txd, 1, "R1", "txd in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd, 1, "R1", "txd after reset");
    chk(s_ready, 1, "R1", "ready after reset");
    repeat (3) begin
      pulse();
      chk(txd, 1, "R1", "idle tick");
    end
    // directed corners
    send(8'hA5, 1, 1, 0, 0, 0, 0, 0);   // static command
    send(8'h3C, 1, 0, 0, 1, 0, 1, 0);   // static data, sideband ignored
    send(8'h00, 1, 1, 1, 0, 0, 2, 0);   // variable: data despite static cmd
    send(8'hFF, 1, 0, 1, 1, 0, 0, 1);   // variable: command, stray valid
    send(8'h81, 0, 1, 1, 1, 1, 3, 0);   // single start bit, config churn
    send(8'h5A, 1, 1, 0, 1, 1, 0, 1);
    // constrained random
    for (int i = 0; i < 40; i++)
      send(DW'($urandom), 1'($urandom_range(0, 3) != 0), 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), $urandom_range(0, 3), 1'($urandom));
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule